// File: doc/BRIEF.md
# Serial Link Transmitter Power and Lock Sequencer

This block decides, cycle by cycle, what the output stage of a serial link transmitter is allowed to do. It watches a run request pin (low means power down), a flag that reports whether the input buffer supply is present, and the parallel reference clock that it runs on. When the transmitter is asked to run, the block first connects the line termination and holds the line at zero differential for a fixed lock interval. This interval stands in for the time the clock multiplier needs to settle. Only after that interval does it declare the serial data valid. Removing the request or the supply returns the stage to high impedance with the termination disconnected.

Alongside the sequencing, the block screens the clock band select and the edge phase-spreading select. Combinations that must not be used are flagged, and an effective spreading code is produced with spreading turned off in those cases. The analog clock multiplier and the line driver sit outside this block and act on its outputs.

Top module: `link_pwr_seq`

## Requirements
- R1: After reset, and whenever the block is powered down, the outputs are out_hiz=1, term_on=0, drive_zero=0, data_valid=0.
- R2: The run condition (run_req high and supply_ok high) passes through a two-flop synchronizer. Its effect on the outputs appears after the third rising clock edge that samples it, and not after the second.
- R3: Once locking starts, data_valid stays low for exactly LOCK_CYCLES (default 16385) clock edges and rises on the next one.
- R4: While locking, the outputs are out_hiz=0, term_on=1, drive_zero=1, data_valid=0.
- R5: While active, the outputs are out_hiz=0, term_on=1, drive_zero=0, data_valid=1.
- R6: With supply_ok low the block is powered down whatever run_req is. A loss of supply during active operation reaches the outputs after three edges.
- R7: run_req going low during locking or active operation returns the outputs to the powered-down state after three edges. A following lock restarts the count from zero.
- R8: spread_sel=11 is reserved. One edge later, mode_bad=1 and spread_eff=00.
- R9: spread_sel=10 (large step) with rate_sel=00 or 01 gives mode_bad=1 and spread_eff=00 one edge later. With rate_sel=10 or 11 it passes through as spread_eff=10 with mode_bad=0.
- R10: spread_sel=00 (off) and 01 (small step) pass through to spread_eff one edge later with mode_bad=0, for every rate_sel.
- R11: If the synchronized power-down reaches the controller on the same edge that the lock count completes, power-down wins: the outputs go to the powered-down state and data_valid never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel reference clock |
| rst | input | 1 | Synchronous active-high reset |
| run_req | input | 1 | Run request; low asks for power down (asynchronous) |
| supply_ok | input | 1 | Input buffer supply present (asynchronous) |
| rate_sel | input | 2 | Clock band select: 00 3-5 MHz, 01 5-10, 10 10-20, 11 20-35 |
| spread_sel | input | 2 | Phase spreading select: 00 off, 01 small, 10 large, 11 reserved |
| out_hiz | output | 1 | Driver released and termination open |
| term_on | output | 1 | Line termination connected |
| drive_zero | output | 1 | Line held at zero differential |
| data_valid | output | 1 | Serial data may be driven |
| mode_bad | output | 1 | Illegal band/spreading combination seen |
| spread_eff | output | 2 | Spreading code actually applied |

## Verification
The two functions that can fall in the same cycle are completion of the lock count and arrival of a synchronized power-down. The bench provokes the overlap by dropping run_req exactly LOCK_CYCLES edges after it raised it. The low level then leaves the synchronizer on the very edge where the count would finish. The result is judged at the ports: the outputs must still read as locking two edges later and as powered down one edge after that, and data_valid must stay low throughout.

// File: rtl/link_pwr_pkg.sv
package link_pwr_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOCK = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        SPR_OFF   = 2'b00,
        SPR_SMALL = 2'b01,
        SPR_LARGE = 2'b10,
        SPR_RSVD  = 2'b11
    } spread_t;

    localparam logic [1:0] RATE_10_20 = 2'b10;

    typedef struct packed {
        logic hiz;
        logic term;
        logic zero;
        logic valid;
    } pad_ctl_t;

    typedef struct packed {
        logic       bad;
        logic [1:0] eff;
    } mode_res_t;

    function automatic pad_ctl_t pad_for_state(seq_state_t s);
        pad_ctl_t p;
        case (s)
            ST_LOCK: p = '{hiz: 1'b0, term: 1'b1, zero: 1'b1, valid: 1'b0};
            ST_RUN:  p = '{hiz: 1'b0, term: 1'b1, zero: 1'b0, valid: 1'b1};
            default: p = '{hiz: 1'b1, term: 1'b0, zero: 1'b0, valid: 1'b0};
        endcase
        return p;
    endfunction

    function automatic mode_res_t screen_mode(logic [1:0] rate, logic [1:0] spread);
        mode_res_t r;
        r.bad = (spread == SPR_RSVD) || ((spread == SPR_LARGE) && (rate < RATE_10_20));
        r.eff = r.bad ? SPR_OFF : spread;
        return r;
    endfunction

endpackage

// File: rtl/link_pwr_sync.sv
module link_pwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/link_pwr_lockcnt.sv
module link_pwr_lockcnt #(
    parameter int LOCK_CYCLES = 16385
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    output logic done
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !count_en) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = count_en && (cnt == LAST);
endmodule

// File: rtl/link_pwr_modechk.sv
module link_pwr_modechk
    import link_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    input  logic [1:0] spread_sel,
    output mode_res_t  res
);
    always_ff @(posedge clk) begin
        if (rst) res <= '{bad: 1'b0, eff: SPR_OFF};
        else     res <= screen_mode(rate_sel, spread_sel);
    end
endmodule

// File: rtl/link_pwr_seq.sv
module link_pwr_seq
    import link_pwr_pkg::*;
#(
    parameter int LOCK_CYCLES = 16385,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_req,
    input  logic       supply_ok,
    input  logic [1:0] rate_sel,
    input  logic [1:0] spread_sel,
    output logic       out_hiz,
    output logic       term_on,
    output logic       drive_zero,
    output logic       data_valid,
    output logic       mode_bad,
    output logic [1:0] spread_eff
);
    logic       run_s;
    logic       lock_done;
    seq_state_t state, state_nx;
    pad_ctl_t   pad;
    mode_res_t  mode;

    link_pwr_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (run_req & supply_ok),
        .q   (run_s)
    );

    link_pwr_lockcnt #(.LOCK_CYCLES(LOCK_CYCLES)) lock_i (
        .clk      (clk),
        .rst      (rst),
        .count_en (state == ST_LOCK),
        .done     (lock_done)
    );

    link_pwr_modechk mode_i (
        .clk        (clk),
        .rst        (rst),
        .rate_sel   (rate_sel),
        .spread_sel (spread_sel),
        .res        (mode)
    );

    always_comb begin
        state_nx = state;
        case (state)
            ST_OFF:  if (run_s) state_nx = ST_LOCK;
            ST_LOCK: if (!run_s) state_nx = ST_OFF;
                     else if (lock_done) state_nx = ST_RUN;
            ST_RUN:  if (!run_s) state_nx = ST_OFF;
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= state_nx;
    end

    assign pad        = pad_for_state(state);
    assign out_hiz    = pad.hiz;
    assign term_on    = pad.term;
    assign drive_zero = pad.zero;
    assign data_valid = pad.valid;
    assign mode_bad   = mode.bad;
    assign spread_eff = mode.eff;
endmodule

module link_pwr_seq_chk #(
    parameter int LOCK_CYCLES = 16385
) (
    input logic       clk,
    input logic       rst,
    input logic       supply_ok,
    input logic [1:0] spread_sel,
    input logic       run_s,
    input logic       out_hiz,
    input logic       term_on,
    input logic       drive_zero,
    input logic       data_valid,
    input logic       mode_bad,
    input logic [1:0] spread_eff
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    logic [CW-1:0] zero_run;

    always_ff @(posedge clk) begin
        if (rst || !drive_zero) zero_run <= '0;
        else if (zero_run != CW'(LOCK_CYCLES)) zero_run <= zero_run + 1'b1;
    end

    // R1 R4 R5: exactly one of the three line modes at a time
    a_r1_one_mode: assert property (@(posedge clk) disable iff (rst)
        $countones({out_hiz, drive_zero, data_valid}) == 1);

    a_r3_valid_after_lock: assert property (@(posedge clk) disable iff (rst)
        $rose(data_valid) |-> $past(drive_zero) && zero_run == CW'(LOCK_CYCLES));

    a_r4_term_in_lock: assert property (@(posedge clk) disable iff (rst)
        (drive_zero || data_valid) |-> term_on);

    a_r7_drop_to_off: assert property (@(posedge clk) disable iff (rst)
        !run_s |=> out_hiz);

    a_r6_no_supply: assert property (@(posedge clk) disable iff (rst)
        (!supply_ok && $past(!supply_ok) && $past(!supply_ok, 2) && $past(!supply_ok, 3))
        |-> out_hiz);

    a_r8_reserved: assert property (@(posedge clk) disable iff (rst)
        (spread_sel == 2'b11) |=> (mode_bad && spread_eff == 2'b00));

    a_r10_pass: assert property (@(posedge clk) disable iff (rst)
        (spread_sel[1] == 1'b0) |=> (!mode_bad && spread_eff == $past(spread_sel)));
endmodule

bind link_pwr_seq link_pwr_seq_chk #(.LOCK_CYCLES(LOCK_CYCLES)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .supply_ok  (supply_ok),
    .spread_sel (spread_sel),
    .run_s      (run_s),
    .out_hiz    (out_hiz),
    .term_on    (term_on),
    .drive_zero (drive_zero),
    .data_valid (data_valid),
    .mode_bad   (mode_bad),
    .spread_eff (spread_eff)
);

// File: tb/link_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module link_pwr_seq_tb_top;
    localparam int L = 16385;
    localparam logic [3:0] P_OFF  = 4'b1000;
    localparam logic [3:0] P_LOCK = 4'b0110;
    localparam logic [3:0] P_RUN  = 4'b0101;

    // {rate, spread, exp_bad, exp_eff}
    localparam logic [6:0] MODE_TAB [16] = '{
        {2'b00, 2'b00, 1'b0, 2'b00}, {2'b00, 2'b01, 1'b0, 2'b01},
        {2'b00, 2'b10, 1'b1, 2'b00}, {2'b00, 2'b11, 1'b1, 2'b00},
        {2'b01, 2'b00, 1'b0, 2'b00}, {2'b01, 2'b01, 1'b0, 2'b01},
        {2'b01, 2'b10, 1'b1, 2'b00}, {2'b01, 2'b11, 1'b1, 2'b00},
        {2'b10, 2'b00, 1'b0, 2'b00}, {2'b10, 2'b01, 1'b0, 2'b01},
        {2'b10, 2'b10, 1'b0, 2'b10}, {2'b10, 2'b11, 1'b1, 2'b00},
        {2'b11, 2'b00, 1'b0, 2'b00}, {2'b11, 2'b01, 1'b0, 2'b01},
        {2'b11, 2'b10, 1'b0, 2'b10}, {2'b11, 2'b11, 1'b1, 2'b00}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_req = 1'b0;
    logic       supply_ok = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic [1:0] spread_sel = 2'b00;
    logic       out_hiz, term_on, drive_zero, data_valid, mode_bad;
    logic [1:0] spread_eff;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    link_pwr_seq #(.LOCK_CYCLES(L)) dut_i (
        .clk(clk), .rst(rst), .run_req(run_req), .supply_ok(supply_ok),
        .rate_sel(rate_sel), .spread_sel(spread_sel),
        .out_hiz(out_hiz), .term_on(term_on), .drive_zero(drive_zero),
        .data_valid(data_valid), .mode_bad(mode_bad), .spread_eff(spread_eff)
    );

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_pad(string tag, logic [3:0] exp);
        logic [3:0] act;
        act = {out_hiz, term_on, drive_zero, data_valid};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pads hiz/term/zero/valid act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic chk_mode(string tag, logic bad, logic [1:0] eff);
        n_chk++;
        if ({mode_bad, spread_eff} !== {bad, eff}) begin
            n_fail++;
            $display("FAIL %s: mode bad/eff act=%b/%b exp=%b/%b",
                     tag, mode_bad, spread_eff, bad, eff);
        end
    endtask

    initial begin
        #(150000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        chk_pad("R1 reset", P_OFF);
        chk_mode("R10 reset", 1'b0, 2'b00);

        // mode screening table: R8 R9 R10
        for (int i = 0; i < 16; i++) begin
            rate_sel   = MODE_TAB[i][6:5];
            spread_sel = MODE_TAB[i][4:3];
            step(1);
            chk_mode(spread_sel == 2'b11 ? "R8" : (spread_sel == 2'b10 ? "R9" : "R10"),
                     MODE_TAB[i][2], MODE_TAB[i][1:0]);
        end
        rate_sel = 2'b00; spread_sel = 2'b00;

        // R6: request without supply stays off
        run_req = 1'b1;
        step(5);
        chk_pad("R6 no supply", P_OFF);

        // R2: supply arrives, three edges to lock
        supply_ok = 1'b1;
        step(2);
        chk_pad("R2 two edges", P_OFF);
        step(1);
        chk_pad("R2 R4 lock", P_LOCK);
        step(100);
        chk_pad("R4 lock hold", P_LOCK);

        // R7: drop during lock
        run_req = 1'b0;
        step(2);
        chk_pad("R7 still lock", P_LOCK);
        step(1);
        chk_pad("R7 off", P_OFF);

        // R3 R7: relock counts full interval
        run_req = 1'b1;
        step(3);
        chk_pad("R7 relock", P_LOCK);
        step(L - 1);
        chk_pad("R3 last lock", P_LOCK);
        step(1);
        chk_pad("R3 R5 active", P_RUN);
        step(3);
        chk_pad("R5 active hold", P_RUN);

        // R6: supply loss while active
        supply_ok = 1'b0;
        step(2);
        chk_pad("R6 active hold", P_RUN);
        step(1);
        chk_pad("R6 off", P_OFF);

        // R11: power-down lands on lock completion edge
        supply_ok = 1'b1;
        step(L);
        run_req = 1'b0;
        step(2);
        chk_pad("R11 lock", P_LOCK);
        step(1);
        chk_pad("R11 off", P_OFF);
        step(5);
        chk_pad("R11 stays off", P_OFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule